// File: doc/BRIEF.md
# Gated Clock Divider With Source Select

This block picks one of two clock sources with a static select line and fans the chosen clock out to two output banks. Bank A repeats the chosen clock at its own rate. Bank B runs at half that rate, driven by a divide-by-two flop. Every output pin has a complement pin. All pairs within a bank carry the same waveform.

An enable input may change at any moment, with no timing relation to either clock. Inside the block it passes through a synchronizer clocked on the falling edge of the chosen clock. Because of this, gating starts and stops only while the clock is low. Every pulse that reaches an output is a full-width pulse. While the block is disabled, every true output sits low and every complement output sits high.

An active-high asynchronous master reset clears the divider and the synchronizer. The select line is treated as configuration: change it only while the outputs are disabled.

Top module: `clk_gate_div`

## Requirements
- R1: With `sel_i` low (encoding 0), the block is driven by `clk_a_i`. With `sel_i` high (encoding 1), it is driven by `clk_b_i`. The period of `qa_o` equals the period of the chosen source.
- R2: While the synchronized enable is high, every `qa_o` bit is high exactly during the high phase of the chosen clock.
- R3: While the synchronized enable is low, all `qa_o` and `qb_o` bits are 0 and all `qa_n_o` and `qb_n_o` bits are 1.
- R4: `en_i` is retimed by two falling edges of the chosen clock (default `SYNC_STAGES`=2). After `en_i` rises 5 ns past a rising edge of a 20 ns clock, the first `qa_o` rising edge comes 35 ns later. After `en_i` falls at the same phase, exactly one more `qa_o` pulse is produced.
- R5: No output pulse is ever shortened, even when `en_i` toggles at arbitrary times. Each `qa_o` high pulse lasts half a chosen-clock period. Each `qb_o` high pulse lasts one full chosen-clock period.
- R6: While enabled, `qb_o` produces one rising edge for every two rising edges of `qa_o`.
- R7: After reset or after re-enable, the first edge on `qb_o` is a rising edge. Every `qb_o` rising edge occurs at the same instant as a `qa_o` rising edge.
- R8: At all times, `qa_n_o` is the bitwise inverse of `qa_o`, and `qb_n_o` is the bitwise inverse of `qb_o`.
- R9: While `mr_i` is high, the divider and synchronizer are cleared and the outputs take the disabled state of R3. After `mr_i` falls, enabling takes the full latency of R4 again. While `mr_i` is low, it has no effect.
- R10: All pairs within one bank carry identical values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a_i | input | 1 | First clock source (selected when `sel_i`=0) |
| clk_b_i | input | 1 | Second clock source (selected when `sel_i`=1) |
| sel_i | input | 1 | Source select, static while enabled |
| en_i | input | 1 | Asynchronous output enable |
| mr_i | input | 1 | Active-high asynchronous master reset |
| qa_o | output | PAIRS_A | Bank A true outputs, divide by 1 |
| qa_n_o | output | PAIRS_A | Bank A complement outputs |
| qb_o | output | PAIRS_B | Bank B true outputs, divide by 2 |
| qb_n_o | output | PAIRS_B | Bank B complement outputs |

## Verification
A synchronizer that updates on the wrong edge shows up at the first enable change: a bank A pulse that is narrower than half a period, or a start latency different from 35 ns. A divider left high when gating stops shows up as a `qb_o` that stays high while disabled, or as a first `qb_o` edge that falls or is misaligned with `qa_o`. Both faults appear within a single chosen-clock period. They are caught by pulse-width and alignment monitors that run while `en_i` toggles at pseudo-random instants on both sources.

// File: rtl/clk_gate_div_pkg.sv
package clk_gate_div_pkg;
  typedef enum logic {SRC_A = 1'b0, SRC_B = 1'b1} src_e;
  localparam int unsigned MIN_SYNC = 2;
endpackage

// File: rtl/cgd_src_mux.sv
module cgd_src_mux
  import clk_gate_div_pkg::*;
(
  input  logic clk_a_i,
  input  logic clk_b_i,
  input  logic sel_i,
  output logic clk_o
);
  src_e src;
  assign src   = src_e'(sel_i);
  assign clk_o = (src == SRC_B) ? clk_b_i : clk_a_i;
endmodule

// File: rtl/cgd_en_sync.sv
module cgd_en_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic mr_i,
  input  logic en_i,
  output logic en_o
);
  logic [STAGES-1:0] stg_q;

  // falling-edge chain: gate changes only while clock is low
  always_ff @(negedge clk_i or posedge mr_i) begin
    if (mr_i) stg_q <= '0;
    else      stg_q <= {stg_q[STAGES-2:0], en_i};
  end

  assign en_o = stg_q[STAGES-1];
endmodule

// File: rtl/cgd_div2.sv
module cgd_div2 (
  input  logic clk_i,
  input  logic mr_i,
  input  logic run_i,
  output logic q_o
);
  logic q_q;

  // parks low when stopped, so a restart always begins with a rise
  always_ff @(posedge clk_i or posedge mr_i) begin
    if (mr_i)       q_q <= 1'b0;
    else if (run_i) q_q <= ~q_q;
    else            q_q <= 1'b0;
  end

  assign q_o = q_q;
endmodule

// File: rtl/cgd_out_bank.sv
module cgd_out_bank #(
  parameter int unsigned PAIRS = 2
) (
  input  logic             src_i,
  output logic [PAIRS-1:0] q_o,
  output logic [PAIRS-1:0] qn_o
);
  for (genvar i = 0; i < PAIRS; i++) begin : g_pair
    assign q_o[i]  = src_i;
    assign qn_o[i] = ~src_i;
  end
endmodule

// File: rtl/clk_gate_div.sv
module clk_gate_div
  import clk_gate_div_pkg::*;
#(
  parameter int unsigned PAIRS_A     = 2,
  parameter int unsigned PAIRS_B     = 2,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic               clk_a_i,
  input  logic               clk_b_i,
  input  logic               sel_i,
  input  logic               en_i,
  input  logic               mr_i,
  output logic [PAIRS_A-1:0] qa_o,
  output logic [PAIRS_A-1:0] qa_n_o,
  output logic [PAIRS_B-1:0] qb_o,
  output logic [PAIRS_B-1:0] qb_n_o
);
  localparam int unsigned SYNC_N = (SYNC_STAGES < MIN_SYNC) ? MIN_SYNC : SYNC_STAGES;

  logic clk_mux;
  logic gate_en;
  logic clk_gated;
  logic div_q;

  cgd_src_mux u_mux (
    .clk_a_i (clk_a_i),
    .clk_b_i (clk_b_i),
    .sel_i   (sel_i),
    .clk_o   (clk_mux)
  );

  cgd_en_sync #(.STAGES(SYNC_N)) u_sync (
    .clk_i (clk_mux),
    .mr_i  (mr_i),
    .en_i  (en_i),
    .en_o  (gate_en)
  );

  // gate_en only moves while clk_mux is low
  assign clk_gated = clk_mux & gate_en;

  cgd_div2 u_div (
    .clk_i (clk_mux),
    .mr_i  (mr_i),
    .run_i (gate_en),
    .q_o   (div_q)
  );

  cgd_out_bank #(.PAIRS(PAIRS_A)) u_bank_a (
    .src_i (clk_gated),
    .q_o   (qa_o),
    .qn_o  (qa_n_o)
  );

  cgd_out_bank #(.PAIRS(PAIRS_B)) u_bank_b (
    .src_i (div_q),
    .q_o   (qb_o),
    .qn_o  (qb_n_o)
  );
endmodule

// File: rtl/clk_gate_div_chk.sv
module clk_gate_div_chk #(
  parameter int unsigned PAIRS_A = 2,
  parameter int unsigned PAIRS_B = 2
) (
  input logic               clk_i,
  input logic               mr_i,
  input logic               gate_en_i,
  input logic [PAIRS_A-1:0] qa_i,
  input logic [PAIRS_A-1:0] qa_n_i,
  input logic [PAIRS_B-1:0] qb_i,
  input logic [PAIRS_B-1:0] qb_n_i
);
  // R8
  comp_a_chk: assert property (@(negedge clk_i) disable iff (mr_i) qa_n_i == ~qa_i);
  // R8
  comp_b_chk: assert property (@(posedge clk_i) disable iff (mr_i) qb_n_i == ~qb_i);
  // R10
  pairs_a_chk: assert property (@(negedge clk_i) disable iff (mr_i) qa_i == {PAIRS_A{qa_i[0]}});
  // R3
  hold_a_chk: assert property (@(negedge clk_i) disable iff (mr_i) !gate_en_i |-> qa_i == '0);
  // R3
  hold_b_chk: assert property (@(posedge clk_i) disable iff (mr_i) !gate_en_i |=> qb_i == '0);
  // R6
  toggle_b_chk: assert property (@(posedge clk_i) disable iff (mr_i) gate_en_i |=> qb_i[0] != $past(qb_i[0]));
  // R7
  start_b_chk: assert property (@(posedge clk_i) disable iff (mr_i)
    $rose(gate_en_i) |-> (qb_i == '0) ##1 (qb_i == {PAIRS_B{1'b1}}));
endmodule

bind clk_gate_div clk_gate_div_chk #(.PAIRS_A(PAIRS_A), .PAIRS_B(PAIRS_B)) u_chk (
  .clk_i     (clk_mux),
  .mr_i      (mr_i),
  .gate_en_i (gate_en),
  .qa_i      (qa_o),
  .qa_n_i    (qa_n_o),
  .qb_i      (qb_o),
  .qb_n_i    (qb_n_o)
);

// File: tb/clk_gate_div_test.sv
`timescale 1ns/1ps
module clk_gate_div_test;
  localparam int PA = 2;
  localparam int PB = 2;

  logic clk_a = 1'b0;
  logic clk_b = 1'b0;
  logic sel = 1'b0;
  logic en = 1'b0;
  logic mr = 1'b1;
  logic [PA-1:0] qa, qa_n;
  logic [PB-1:0] qb, qb_n;

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;
  bit mon_on = 0;
  int half = 10;
  int a_rise_t = 0, b_rise_t = 0, a_per = 0;
  int a_rises = 0, b_rises = 0;

  clk_gate_div #(.PAIRS_A(PA), .PAIRS_B(PB)) uut (
    .clk_a_i (clk_a),
    .clk_b_i (clk_b),
    .sel_i   (sel),
    .en_i    (en),
    .mr_i    (mr),
    .qa_o    (qa),
    .qa_n_o  (qa_n),
    .qb_o    (qb),
    .qb_n_o  (qb_n)
  );

  // 50 MHz source A, 33.3 MHz source B off-phase
  always #10 clk_a = ~clk_a;
  initial begin
    #3;
    forever #15 clk_b = ~clk_b;
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_err++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // pulse monitors
  always @(posedge qa[0]) begin
    a_per = int'($time) - a_rise_t;
    a_rise_t = int'($time);
    a_rises++;
  end
  always @(negedge qa[0])
    if (mon_on) chk(int'($time) - a_rise_t == half, "R5", "qa high width", int'($time) - a_rise_t, half);
  always @(posedge qb[0]) begin
    b_rise_t = int'($time);
    b_rises++;
    if (mon_on) chk(b_rise_t == a_rise_t, "R7", "qb rise vs qa rise", b_rise_t, a_rise_t);
  end
  always @(negedge qb[0])
    if (mon_on) chk(int'($time) - b_rise_t == 2 * half, "R5", "qb high width", int'($time) - b_rise_t, 2 * half);

  function automatic int pins();
    return int'({qa, qa_n, qb, qb_n});
  endfunction

  task automatic check_static(input string req);
    chk(pins() == 8'h33, req, "disabled output state", pins(), 8'h33);
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk_a);
    #5;
    check_static("R9");
    mr = 1'b0;
    repeat (3) @(posedge clk_a);
    #5;
    check_static("R3");
  endtask

  task automatic t_run_a();
    int t0, a0, b0;
    half = 10;
    mon_on = 1;
    @(posedge clk_a); #5;
    t0 = int'($time);
    en = 1'b1;
    wait (qa[0] === 1'b1);
    chk(int'($time) - t0 == 35, "R4", "enable latency", int'($time) - t0, 35);
    repeat (4) @(posedge clk_a);
    #5;
    a0 = a_rises; b0 = b_rises;
    repeat (20) @(posedge clk_a);
    #5;
    chk(a_rises - a0 == 20, "R2", "qa rises in 20 cycles", a_rises - a0, 20);
    chk(b_rises - b0 == 10, "R6", "qb rises in 20 cycles", b_rises - b0, 10);
    chk(a_per == 20, "R1", "qa period on source A", a_per, 20);
    for (int i = 0; i < 4; i++) begin
      chk(qa == '1, "R2", "qa high phase", int'(qa), 3);
      chk(qa_n == ~qa && qb_n == ~qb, "R8", "complements high phase", int'({qa_n, qb_n}), int'({~qa, ~qb}));
      chk(qb == {PB{qb[0]}}, "R10", "bank B pairs", int'(qb), int'({PB{qb[0]}}));
      #10;
      chk(qa == '0, "R2", "qa low phase", int'(qa), 0);
      chk(qa_n == ~qa && qb_n == ~qb, "R8", "complements low phase", int'({qa_n, qb_n}), int'({~qa, ~qb}));
      #10;
    end
    @(posedge clk_a); #5;
    a0 = a_rises;
    en = 1'b0;
    #100;
    chk(a_rises - a0 == 1, "R4", "pulses after disable", a_rises - a0, 1);
    for (int i = 0; i < 3; i++) begin
      check_static("R3");
      #17;
    end
  endtask

  task automatic t_src_b();
    int a0, b0;
    sel = 1'b1;
    half = 15;
    #100;
    en = 1'b1;
    #200;
    chk(a_per == 30, "R1", "qa period on source B", a_per, 30);
    @(posedge clk_b); #7;
    a0 = a_rises; b0 = b_rises;
    repeat (12) @(posedge clk_b);
    #7;
    chk(a_rises - a0 == 12, "R2", "qa rises on source B", a_rises - a0, 12);
    chk(b_rises - b0 == 6, "R6", "qb rises on source B", b_rises - b0, 6);
    en = 1'b0;
    #150;
    check_static("R3");
    sel = 1'b0;
    half = 10;
    #100;
  endtask

  task automatic t_random_en(input logic s, input int h);
    int a0;
    sel = s;
    half = h;
    #120;
    a0 = a_rises;
    for (int i = 0; i < 60; i++) begin
      #($urandom_range(3, 97));
      en = ~en;
    end
    en = 1'b0;
    #150;
    chk(a_rises > a0, "R5", "pulses seen during random enable", a_rises - a0, 1);
    check_static("R3");
    sel = 1'b0;
    half = 10;
    #100;
  endtask

  task automatic t_mr();
    int t0, b0;
    en = 1'b1;
    #200;
    mon_on = 0;
    @(posedge clk_a); #5;
    mr = 1'b1;
    #2;
    check_static("R9");
    #50;
    check_static("R9");
    @(posedge clk_a); #5;
    b0 = b_rises;
    mon_on = 1;
    t0 = int'($time);
    mr = 1'b0;
    wait (qa[0] === 1'b1);
    chk(int'($time) - t0 == 35, "R9", "latency after master reset", int'($time) - t0, 35);
    #1;
    chk(b_rises - b0 == 1 && qb == '1, "R7", "first qb edge rises", int'(qb), 3);
    #300;
    en = 1'b0;
    #100;
    check_static("R3");
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_run_a();
    t_src_b();
    t_random_en(1'b0, 10);
    t_random_en(1'b1, 15);
    t_mr();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule